// File: doc/BRIEF.md
# Branch Sequencer with Delayed and Non-Delayed Transfers

This block holds the program counter of a small in-order core and decides where the next fetch goes. Each cycle it is given one decoded instruction at the current address. The decoded instruction carries a branch kind, a delay flag, a condition selector, the four arithmetic flags, a register operand and a signed displacement. From these it produces the address of the instruction presented in the next cycle. It also drives a squash indication for the instruction that directly follows a taken branch, a bubble indication for the dead cycle, and the return-pointer register that calls write and returns read.

A branch without the delay flag never lets its fall-through instruction run. When it is taken, that instruction is squashed and the transfer costs one extra cycle. A branch with the delay flag lets exactly one slot instruction run and then lands on the target with no dead cycle. A delayed call writes its return pointer before the slot runs, so the slot already sees the new value. All instructions are halfwords, so the sequential step is 2.

Top module: `branch_seq`

## Requirements
- R1: While reset is asserted, `pc_o` equals the reset address (default 0), `rp_o` is 0, and `bubble_o` is 0.
- R2: A non-branch (kind 0, or the unused kinds 6 and 7) and a conditional branch whose condition fails both advance `pc_o` by 2 in the next cycle, with `squash_o` and `bubble_o` low.
- R3: `ins_flags` is {N,Z,V,C} from bit 3 down to bit 0. The condition code is evaluated as follows:
  - 0 always; 1 never.
  - 2 Z; 3 not Z.
  - 4 C; 5 not C.
  - 6 N; 7 not N.
  - 8 V; 9 not V.
  - 10 N xor V; 11 its inverse.
  - 12 (N xor V) or Z; 13 its inverse.
  - 14 C or Z; 15 its inverse.
- R4: A taken branch without the delay flag raises `squash_o` in its own cycle. The next cycle shows branch address + 2 with `bubble_o` high. The cycle after that shows the target. Taken this way, the branch costs 2 cycles; not taken, it costs 1.
- R5: A taken branch with the delay flag keeps `squash_o` low. Its slot instruction at branch address + 2 is presented with `bubble_o` low, and the target follows directly after.
- R6: Kind encodings and targets:
  - 1: conditional branch to branch address + 2 + 2 × sign-extended `ins_disp[8:0]`. Bits 11:9 are ignored.
  - 2: jump, and 4: call, both to `ins_reg` with bit 0 cleared.
  - 3: call to branch address + 2 + 2 × sign-extended `ins_disp[11:0]`.
  - 5: return, to `rp_o`.
  - `pc_o` is always even.
- R7: A call (kind 3 or 4) writes the return pointer, and the new value is visible on `rp_o` from the next cycle, including in a delay slot. Without the delay flag the value is branch address + 2. With the delay flag it is branch address + 4.
- R8: A branch kind presented as a delay-slot instruction raises `slot_err_o` in that cycle. It is otherwise treated as a non-branch: no squash, no return-pointer write, and no change to the pending target.
- R9: The instruction presented during a bubble cycle is ignored: no squash, no slot error, no return-pointer write, and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_kind | input | 3 | Branch kind of the presented instruction (encoding in R6) |
| ins_delay | input | 1 | Delay flag: one slot instruction executes before the transfer |
| ins_cond | input | 4 | Condition selector for kind 1 |
| ins_flags | input | 4 | Flags {N,Z,V,C} |
| ins_reg | input | AW | Register operand for jump and call through register |
| ins_disp | input | 12 | Signed halfword displacement |
| pc_o | output | AW | Address of the instruction presented this cycle |
| squash_o | output | 1 | The instruction after the current one will be squashed |
| bubble_o | output | 1 | The current cycle is a squashed, dead cycle |
| slot_err_o | output | 1 | A branch was presented in a delay slot |
| rp_o | output | AW | Return-pointer register |

## Verification
The bench walks every condition code with flag patterns that separate each one from its neighbour. A swapped or inverted encoding therefore shows up as a wrong squash, or as a PC that fails to redirect. Delayed and non-delayed transfers are compared cycle by cycle: a design that squashes the slot, or leaves out the dead cycle, lands on the target one cycle early or late. Further directed cases cover these faults:
- A delayed call whose return pointer is written late, or as +2 instead of +4.
- A branch placed in a delay slot that redirects or writes the return pointer.
- Garbage presented during the bubble that leaks into state.
- Displacement extremes and upper displacement bits that a conditional branch must ignore.

// File: rtl/bs_pkg.sv
package bs_pkg;
  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_COND  = 3'd1,
    BK_JREG  = 3'd2,
    BK_CALL  = 3'd3,
    BK_CALLR = 3'd4,
    BK_RET   = 3'd5
  } br_kind_t;

  localparam logic [3:0] CC_LT = 4'd10;
endpackage

// File: rtl/bs_rst_sync.sv
module bs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/bs_cond_eval.sv
module bs_cond_eval (
  input  logic [3:0] cc,
  input  logic [3:0] flg,
  output logic       hit
);
  logic fn, fz, fv, fc, base;

  assign fn = flg[3];
  assign fz = flg[2];
  assign fv = flg[1];
  assign fc = flg[0];

  // Pairs share a base test; the low bit of the code inverts it.
  always_comb begin
    unique case (cc[3:1])
      3'd0:    base = 1'b1;
      3'd1:    base = fz;
      3'd2:    base = fc;
      3'd3:    base = fn;
      3'd4:    base = fv;
      3'd5:    base = fn ^ fv;
      3'd6:    base = (fn ^ fv) | fz;
      default: base = fc | fz;
    endcase
  end

  assign hit = base ^ cc[0];
endmodule

// File: rtl/bs_target.sv
module bs_target
  import bs_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 12,
  parameter int CDW = 9
) (
  input  br_kind_t          kind,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     regv,
  input  logic [AW-1:0]     rp,
  input  logic [DW-1:0]     disp,
  output logic [AW-1:0]     tgt
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] seq, off_c, off_l;

  assign seq   = pc + STEP;
  assign off_c = {{(AW-CDW-1){disp[CDW-1]}}, disp[CDW-1:0], 1'b0};
  assign off_l = {{(AW-DW-1){disp[DW-1]}}, disp, 1'b0};

  always_comb begin
    unique case (kind)
      BK_COND:           tgt = seq + off_c;
      BK_CALL:           tgt = seq + off_l;
      BK_JREG, BK_CALLR: tgt = regv & ~AW'(1);
      BK_RET:            tgt = rp;
      default:           tgt = seq;
    endcase
  end
endmodule

// File: rtl/bs_link_reg.sv
module bs_link_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import bs_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 12,
  parameter int          CDW      = 9,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ins_kind,
  input  logic          ins_delay,
  input  logic [3:0]    ins_cond,
  input  logic [3:0]    ins_flags,
  input  logic [AW-1:0] ins_reg,
  input  logic [DW-1:0] ins_disp,
  output logic [AW-1:0] pc_o,
  output logic          squash_o,
  output logic          bubble_o,
  output logic          slot_err_o,
  output logic [AW-1:0] rp_o
);
  localparam logic [AW-1:0] STEP   = AW'(2);
  localparam logic [AW-1:0] STEP2  = AW'(4);
  localparam logic [AW-1:0] PC_RST = AW'(RESET_PC) & ~AW'(1);

  logic          rst_q_n;
  br_kind_t      kind;
  logic          is_br, eff_br, cond_hit, taken, is_call;
  logic [AW-1:0] tgt;
  logic [AW-1:0] pc_q, pc_d, tgt_q;
  logic          bubble_q, bubble_d, slot_q, slot_d;

  bs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  bs_cond_eval u_cond (.cc(ins_cond), .flg(ins_flags), .hit(cond_hit));

  bs_target #(.AW(AW), .DW(DW), .CDW(CDW)) u_tgt (
    .kind(kind), .pc(pc_q), .regv(ins_reg), .rp(rp_o), .disp(ins_disp), .tgt(tgt)
  );

  bs_link_reg #(.AW(AW)) u_rp (
    .clk(clk), .rst_n(rst_q_n), .en(is_call),
    .d(pc_q + (ins_delay ? STEP2 : STEP)), .q(rp_o)
  );

  // Decode the current instruction; a bubble cycle decodes as nothing.
  always_comb begin
    kind = br_kind_t'(ins_kind);
    is_br = !bubble_q && (ins_kind >= 3'd1) && (ins_kind <= 3'd5);
    eff_br = is_br && !slot_q;
    taken = eff_br && ((kind != BK_COND) || cond_hit);
    is_call = eff_br && ((kind == BK_CALL) || (kind == BK_CALLR));
  end

  // Next-state: a bubble or a slot hands over to the held target.
  always_comb begin
    pc_d     = (bubble_q || slot_q) ? tgt_q : pc_q + STEP;
    bubble_d = taken && !ins_delay;
    slot_d   = taken && ins_delay;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q     <= PC_RST;
      bubble_q <= 1'b0;
      slot_q   <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      bubble_q <= bubble_d;
      slot_q   <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) tgt_q <= PC_RST;
    else if (taken) tgt_q <= tgt;
  end

  assign pc_o       = pc_q;
  assign squash_o   = bubble_d;
  assign bubble_o   = bubble_q;
  assign slot_err_o = is_br && slot_q;
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    kind,
  input logic          delay,
  input logic          slot_q,
  input logic [AW-1:0] pc,
  input logic          squash,
  input logic          bubble,
  input logic          slot_err,
  input logic [AW-1:0] rp
);
  logic live_head;
  assign live_head = !bubble && !slot_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd0 && live_head) |=> pc == $past(pc) + AW'(2)); // R2
  AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> bubble); // R4
  AST_SQUASH_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> pc == $past(pc) + AW'(2)); // R4
  AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble); // R4
  AST_DELAY_NO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (delay && kind != 3'd0 && live_head) |-> !squash); // R5
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pc[0] == 1'b0); // R6
  AST_DCALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (delay && (kind == 3'd3 || kind == 3'd4) && live_head)
      |=> rp == $past(pc) + AW'(4)); // R7
  AST_SLOT_ERR_NO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |-> !squash); // R8
  AST_SLOT_ERR_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |=> $stable(rp)); // R8
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (!squash && !slot_err)); // R9
  AST_BUBBLE_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> $stable(rp)); // R9
endmodule

bind branch_seq bs_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .kind(ins_kind), .delay(ins_delay),
  .slot_q(slot_q), .pc(pc_o), .squash(squash_o), .bubble(bubble_o),
  .slot_err(slot_err_o), .rp(rp_o)
);

// File: tb/sim_branch_seq.sv
`timescale 1ns/1ps
module sim_branch_seq;
  localparam logic [2:0] K_NONE = 3'd0, K_COND = 3'd1, K_JREG = 3'd2,
                         K_CALL = 3'd3, K_CALLR = 3'd4, K_RET = 3'd5;
  localparam int NV = 17;
  // {cond[3:0], flags NZVC[3:0], expected taken}
  localparam logic [8:0] VEC [NV] = '{
    {4'd0,  4'b0000, 1'b1}, {4'd1,  4'b1111, 1'b0}, {4'd2,  4'b0100, 1'b1},
    {4'd3,  4'b0100, 1'b0}, {4'd4,  4'b0001, 1'b1}, {4'd5,  4'b0001, 1'b0},
    {4'd6,  4'b1000, 1'b1}, {4'd7,  4'b0000, 1'b1}, {4'd8,  4'b0010, 1'b1},
    {4'd9,  4'b0010, 1'b0}, {4'd10, 4'b1000, 1'b1}, {4'd11, 4'b1010, 1'b1},
    {4'd12, 4'b0100, 1'b1}, {4'd13, 4'b0000, 1'b1}, {4'd13, 4'b1000, 1'b0},
    {4'd14, 4'b0000, 1'b0}, {4'd15, 4'b0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ins_kind;
  logic        ins_delay;
  logic [3:0]  ins_cond, ins_flags;
  logic [31:0] ins_reg;
  logic [11:0] ins_disp;
  logic [31:0] pc_o, rp_o;
  logic        squash_o, bubble_o, slot_err_o;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] cur, saved_rp;

  always #5 clk = ~clk;

  branch_seq u0 (
    .clk(clk), .rst_n(rst_n), .ins_kind(ins_kind), .ins_delay(ins_delay),
    .ins_cond(ins_cond), .ins_flags(ins_flags), .ins_reg(ins_reg),
    .ins_disp(ins_disp), .pc_o(pc_o), .squash_o(squash_o), .bubble_o(bubble_o),
    .slot_err_o(slot_err_o), .rp_o(rp_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic d, input logic [3:0] c,
                       input logic [3:0] f, input logic [31:0] r, input logic [11:0] dp);
    ins_kind = k; ins_delay = d; ins_cond = c; ins_flags = f; ins_reg = r; ins_disp = dp;
    #1;
  endtask

  task automatic idle();
    drive(K_NONE, 1'b0, 4'd0, 4'd0, 32'd0, 12'd0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", pc_o, 32'h0);
    chk("R1 rp in reset", rp_o, 32'h0);
    chk("R1 bubble in reset", {31'd0, bubble_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Condition table, non-delayed branches with displacement +6 halfwords.
    for (int i = 0; i < NV; i++) begin
      cur = pc_o;
      drive(K_COND, 1'b0, VEC[i][8:5], VEC[i][4:1], 32'd0, 12'd6);
      chk($sformatf("R3 squash for cond %0d", VEC[i][8:5]), {31'd0, squash_o}, {31'd0, VEC[i][0]});
      @(negedge clk); idle();
      chk("R2/R4 fall-through pc", pc_o, cur + 32'd2);
      chk("R2/R4 bubble", {31'd0, bubble_o}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        @(negedge clk);
        chk("R4 pc at target", pc_o, cur + 32'd14);
        chk("R4 bubble cleared", {31'd0, bubble_o}, 32'd0);
      end
    end

    // R6 jump through register, bit 0 cleared.
    drive(K_JREG, 1'b0, 4'd0, 4'd0, 32'h8001, 12'd0);
    chk("R4 jump squash", {31'd0, squash_o}, 32'd1);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R6 jump target", pc_o, 32'h8000);

    // R5 delayed taken conditional, negative displacement.
    cur = pc_o;
    drive(K_COND, 1'b1, 4'd0, 4'd0, 32'd0, 12'hFFC);
    chk("R5 delayed no squash", {31'd0, squash_o}, 32'd0);
    @(negedge clk); idle();
    chk("R5 slot pc", pc_o, cur + 32'd2);
    chk("R5 slot not bubble", {31'd0, bubble_o}, 32'd0);
    @(negedge clk);
    chk("R5 target right after slot", pc_o, cur - 32'd6);

    // R6 conditional ignores displacement bits 11:9 (low 9 bits = -256).
    cur = pc_o;
    drive(K_COND, 1'b0, 4'd0, 4'd0, 32'd0, 12'hF00);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R6 cond disp9 min", pc_o, cur + 32'd2 - 32'd512);

    // R7 non-delayed call, max displacement.
    cur = pc_o;
    drive(K_CALL, 1'b0, 4'd0, 4'd0, 32'd0, 12'h7FF);
    @(negedge clk); idle();
    chk("R7 call link +2", rp_o, cur + 32'd2);
    @(negedge clk);
    chk("R6 call disp12 max", pc_o, cur + 32'd2 + 32'd4094);

    // R9 return with garbage in the bubble cycle.
    cur = pc_o;
    saved_rp = rp_o;
    drive(K_RET, 1'b0, 4'd0, 4'd0, 32'd0, 12'd0);
    chk("R4 ret squash", {31'd0, squash_o}, 32'd1);
    @(negedge clk);
    drive(K_CALL, 1'b1, 4'd0, 4'd0, 32'd0, 12'h010);
    chk("R9 bubble squash ignored", {31'd0, squash_o}, 32'd0);
    chk("R9 bubble no slot error", {31'd0, slot_err_o}, 32'd0);
    @(negedge clk); idle();
    chk("R6 ret target", pc_o, saved_rp);
    chk("R9 rp unchanged by bubble", rp_o, saved_rp);

    // R7/R8 delayed call through register with a branch in its slot.
    cur = pc_o;
    drive(K_CALLR, 1'b1, 4'd0, 4'd0, 32'h4001, 12'd0);
    chk("R5 delayed call no squash", {31'd0, squash_o}, 32'd0);
    @(negedge clk);
    chk("R7 slot sees new rp", rp_o, cur + 32'd4);
    chk("R5 slot pc", pc_o, cur + 32'd2);
    saved_rp = cur + 32'd4;
    drive(K_CALL, 1'b0, 4'd0, 4'd0, 32'd0, 12'h100);
    chk("R8 slot error flagged", {31'd0, slot_err_o}, 32'd1);
    chk("R8 slot branch no squash", {31'd0, squash_o}, 32'd0);
    @(negedge clk); idle();
    chk("R8 pc goes to call target", pc_o, 32'h4000);
    chk("R8 rp not rewritten", rp_o, saved_rp);
    @(negedge clk);
    chk("R8 no redirect from illegal", pc_o, 32'h4002);

    // R5 delayed return.
    cur = pc_o;
    drive(K_RET, 1'b1, 4'd0, 4'd0, 32'd0, 12'd0);
    @(negedge clk); idle();
    chk("R5 ret slot pc", pc_o, cur + 32'd2);
    @(negedge clk);
    chk("R5 delayed ret target", pc_o, saved_rp);

    // R7 non-delayed call, min displacement; R2 unused kind.
    cur = pc_o;
    drive(K_CALL, 1'b0, 4'd0, 4'd0, 32'd0, 12'h800);
    @(negedge clk); idle();
    chk("R7 call link +2 again", rp_o, cur + 32'd2);
    @(negedge clk);
    chk("R6 call disp12 min", pc_o, cur + 32'd2 - 32'd4096);
    cur = pc_o;
    drive(3'd7, 1'b0, 4'd0, 4'd0, 32'd0, 12'd0);
    chk("R2 unused kind no squash", {31'd0, squash_o}, 32'd0);
    @(negedge clk); idle();
    chk("R2 unused kind steps", pc_o, cur + 32'd2);

    finish_up();
  end
endmodule